// File: doc/BRIEF.md
# Dual-Compare Interval Timer

This block is a 16-bit interval timer with two maximum-count registers. Software sets it up through a small word-wide register port: a control word, the live count, and the two limits A and B. Once running, the counter takes one step per tick. A tick comes from one of three places: a divide-by-four prescaler on the system clock, rising edges on an asynchronous external count pin, or a pulse input chained from another timer's terminal-count output.

When the next step would reach the active limit, the count returns to zero instead. This is the terminal count. It raises a one-clock terminal pulse and, if enabled, a one-clock interrupt request. A limit of zero gives a full 65536-step period.

There are two output modes. In alternate mode the timer counts to A, then to B, and repeats, and the output pin shows which half is in progress. This produces a waveform whose duty cycle is set by the two limits. In single-limit mode the pin drops low for one tick at each terminal count. When the repeat bit is clear, the timer clears its own run bit at the end of a run.

Top module: `dct_top`

## Requirements
- R1: After reset the control word, count and both limits read 0, `irq_o` and `tc_o` are 0, and `tmr_out_o` is 1.
- R2: With source 00 (internal) and run bit 0 of control set, the count rises by one every fourth clock; while the run bit is 0 the count does not move.
- R3: On a tick where count+1 (modulo 2^16) equals the active limit, the count becomes 0. One clock later `irq_o` pulses for one clock if control bit 3 is set, and stays 0 if it is clear.
- R4: A limit of 0 gives a period of 65536 ticks: the count passes through FFFFh and wraps to 0 with a terminal count, and 0 itself is not terminal.
- R5: With repeat bit 1 of control set, the timer keeps running and produces terminal counts every period.
- R6: With the repeat bit clear, the run bit clears itself at the terminal count. In single-limit mode this happens at every terminal count; in alternate mode it happens only at the terminal count of the B half.
- R7: With alternate bit 2 set, the timer counts to A, then to B, then back to A. Control read bit 6 reads 1 while B is active. `tmr_out_o` is high while counting toward A and low while counting toward B.
- R8: With the alternate bit clear, `tmr_out_o` goes low at a terminal count and returns high at the next tick, or one clock later if the run has ended.
- R9: With source 01 (control bits 5:4), the count advances once per rising edge of `ext_cnt_i`. The pin passes through a two-flop synchronizer, so the count changes three clock edges after the first edge that samples the pin high. A level held high counts only once.
- R10: With source 10 the count advances on every clock in which `casc_tick_i` is high. Source 11 never advances the count.
- R11: `tc_o` is a one-clock pulse after every terminal count, whatever the interrupt-enable bit is.
- R12: Register addresses are 0 control, 1 count (a write loads the counter), 2 limit A, 3 limit B. Reads return the stored values combinationally, and a count write takes priority over counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for the selected register |
| ext_cnt_i | input | 1 | Asynchronous external count pin |
| casc_tick_i | input | 1 | Tick from a chained timer's terminal count |
| irq_o | output | 1 | Interrupt request pulse |
| tc_o | output | 1 | Terminal-count pulse, usable to chain another timer |
| tmr_out_o | output | 1 | Waveform output |

## Verification
The assertions assume that the count changes only through a count-register write or a counting step. They also assume that the run bit and the limit-select state change only through a control write or a terminal count. For that reason, each property excludes the cycle right after a write to the register concerned. The stimulus changes control only by complete writes through the port, and it drives `ext_cnt_i` and `casc_tick_i` at falling edges. It reconfigures a running timer only after stopping it, so every terminal count the bench expects lands at a predictable clock edge.

// File: rtl/dct_pkg.sv
package dct_pkg;

  typedef enum logic [1:0] {
    SRC_INT  = 2'b00,
    SRC_EXT  = 2'b01,
    SRC_CASC = 2'b10,
    SRC_OFF  = 2'b11
  } src_e;

  // control word, LSB first: run, rep, alt, irq_en, src[1:0]
  typedef struct packed {
    src_e src;
    logic irq_en;
    logic alt;
    logic rep;
    logic run;
  } ctrl_t;

  localparam int CTRL_W = 6;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CNT  = 2'd1;
  localparam logic [1:0] ADDR_CMPA = 2'd2;
  localparam logic [1:0] ADDR_CMPB = 2'd3;

endpackage

// File: rtl/dct_rst_sync.sv
module dct_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/dct_tick_gen.sv
module dct_tick_gen
  import dct_pkg::*;
#(
  parameter int PRESC = 4,
  parameter int SYNC  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  src_e src_i,
  input  logic ext_i,
  input  logic casc_i,
  output logic tick_o
);
  localparam int PW = (PRESC > 1) ? $clog2(PRESC) : 1;
  localparam logic [PW-1:0] PLAST = PW'(PRESC - 1);

  logic [PW-1:0]   psc_q, psc_d;
  logic [SYNC-1:0] sync_q;
  logic            prev_q;
  logic            int_tick, ext_rise;

  always_comb begin
    psc_d = psc_q;
    if (!run_i)              psc_d = '0;
    else if (psc_q == PLAST) psc_d = '0;
    else                     psc_d = psc_q + PW'(1);
  end

  assign int_tick = run_i && (psc_q == PLAST);
  assign ext_rise = sync_q[SYNC-1] && !prev_q;

  always_comb begin
    unique case (src_i)
      SRC_INT:  tick_o = int_tick;
      SRC_EXT:  tick_o = ext_rise;
      SRC_CASC: tick_o = casc_i;
      default:  tick_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_q  <= '0;
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      psc_q  <= psc_d;
      sync_q <= {sync_q[SYNC-2:0], ext_i};
      prev_q <= sync_q[SYNC-1];
    end
  end
endmodule

// File: rtl/dct_count_core.sv
module dct_count_core #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_i,
  input  logic         alt_i,
  input  logic [W-1:0] lim_a_i,
  input  logic [W-1:0] lim_b_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  output logic [W-1:0] cnt_o,
  output logic         sel_o,
  output logic         term_o,
  output logic         last_o
);
  logic [W-1:0] cnt_q, cnt_d, inc, lim;
  logic         sel_q, sel_d;

  always_comb begin
    inc    = cnt_q + W'(1);
    lim    = (alt_i && sel_q) ? lim_b_i : lim_a_i;
    term_o = adv_i && (inc == lim);
    last_o = term_o && (!alt_i || sel_q);

    cnt_d = cnt_q;
    if (ld_i)        cnt_d = ld_val_i;
    else if (term_o) cnt_d = '0;
    else if (adv_i)  cnt_d = inc;

    sel_d = sel_q;
    if (!alt_i)      sel_d = 1'b0;
    else if (term_o) sel_d = !sel_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sel_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sel_q <= sel_d;
    end
  end

  assign cnt_o = cnt_q;
  assign sel_o = sel_q;
endmodule

// File: rtl/dct_out_stage.sv
module dct_out_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic term_i,
  input  logic adv_i,
  input  logic run_i,
  input  logic irq_en_i,
  input  logic alt_i,
  input  logic sel_i,
  output logic tc_o,
  output logic irq_o,
  output logic tout_o
);
  logic tc_q, irq_q, low_q;
  logic tc_d, irq_d, low_d;

  always_comb begin
    tc_d  = term_i;
    irq_d = term_i && irq_en_i;
    low_d = low_q;
    if (term_i)                low_d = 1'b1;
    else if (adv_i || !run_i)  low_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tc_q  <= 1'b0;
      irq_q <= 1'b0;
      low_q <= 1'b0;
    end else begin
      tc_q  <= tc_d;
      irq_q <= irq_d;
      low_q <= low_d;
    end
  end

  assign tc_o   = tc_q;
  assign irq_o  = irq_q;
  assign tout_o = alt_i ? !sel_i : !low_q;
endmodule

// File: rtl/dct_top.sv
module dct_top
  import dct_pkg::*;
#(
  parameter int W     = 16,
  parameter int PRESC = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         reg_wr_i,
  input  logic [1:0]   reg_addr_i,
  input  logic [W-1:0] reg_wdata_i,
  output logic [W-1:0] reg_rdata_o,
  input  logic         ext_cnt_i,
  input  logic         casc_tick_i,
  output logic         irq_o,
  output logic         tc_o,
  output logic         tmr_out_o
);
  logic         rst_n_s;
  ctrl_t        ctrl_q, ctrl_d;
  logic [W-1:0] lim_a_q, lim_a_d, lim_b_q, lim_b_d;
  logic [W-1:0] cnt;
  logic         sel, term, last, tick, adv, run, ld_cnt;

  dct_rst_sync #(.STAGES(2)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_s)
  );

  assign run    = ctrl_q.run;
  assign adv    = tick && run;
  assign ld_cnt = reg_wr_i && (reg_addr_i == ADDR_CNT);

  always_comb begin
    ctrl_d  = ctrl_q;
    lim_a_d = lim_a_q;
    lim_b_d = lim_b_q;
    if (reg_wr_i && reg_addr_i == ADDR_CTRL) ctrl_d = ctrl_t'(reg_wdata_i[CTRL_W-1:0]);
    else if (last && !ctrl_q.rep)            ctrl_d.run = 1'b0;
    if (reg_wr_i && reg_addr_i == ADDR_CMPA) lim_a_d = reg_wdata_i;
    if (reg_wr_i && reg_addr_i == ADDR_CMPB) lim_b_d = reg_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ctrl_q  <= '0;
      lim_a_q <= '0;
      lim_b_q <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      lim_a_q <= lim_a_d;
      lim_b_q <= lim_b_d;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      ADDR_CTRL: begin
        reg_rdata_o[CTRL_W-1:0] = ctrl_q;
        reg_rdata_o[CTRL_W]     = sel;
      end
      ADDR_CNT:  reg_rdata_o = cnt;
      ADDR_CMPA: reg_rdata_o = lim_a_q;
      default:   reg_rdata_o = lim_b_q;
    endcase
  end

  dct_tick_gen #(.PRESC(PRESC), .SYNC(2)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_n_s),
    .run_i  (run),
    .src_i  (ctrl_q.src),
    .ext_i  (ext_cnt_i),
    .casc_i (casc_tick_i),
    .tick_o (tick)
  );

  dct_count_core #(.W(W)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_s),
    .adv_i    (adv),
    .alt_i    (ctrl_q.alt),
    .lim_a_i  (lim_a_q),
    .lim_b_i  (lim_b_q),
    .ld_i     (ld_cnt),
    .ld_val_i (reg_wdata_i),
    .cnt_o    (cnt),
    .sel_o    (sel),
    .term_o   (term),
    .last_o   (last)
  );

  dct_out_stage u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_s),
    .term_i   (term),
    .adv_i    (adv),
    .run_i    (run),
    .irq_en_i (ctrl_q.irq_en),
    .alt_i    (ctrl_q.alt),
    .sel_i    (sel),
    .tc_o     (tc_o),
    .irq_o    (irq_o),
    .tout_o   (tmr_out_o)
  );
endmodule

// File: rtl/dct_chk.sv
module dct_chk #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_n,
  input logic         reg_wr,
  input logic [1:0]   reg_addr,
  input logic         irq,
  input logic         tc,
  input logic [W-1:0] cnt,
  input logic         sel,
  input logic         run,
  input logic         alt
);
  // R3: an interrupt pulse only ever accompanies a terminal count
  p_irq_has_tc_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq |-> tc);

  // R3: after a terminal count the counter sits at zero unless it was just loaded
  p_wrap_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (tc && !$past(reg_wr && reg_addr == 2'd1)) |-> (cnt == '0));

  // R2: no movement while stopped
  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!run && !(reg_wr && reg_addr == 2'd1)) |=> $stable(cnt));

  // R2: without a load, the count holds, steps by one, or wraps to zero
  p_single_step_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(reg_wr && reg_addr == 2'd1) |=>
      (cnt == $past(cnt) || cnt == $past(cnt) + W'(1) || cnt == '0));

  // R6: the run bit drops on its own only at a terminal count
  p_self_stop_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    ($fell(run) && !$past(reg_wr && reg_addr == 2'd0)) |-> tc);

  // R7: the active limit swaps only at a terminal count
  p_sel_swap_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (alt && $past(alt) && sel != $past(sel)) |-> tc);
endmodule

bind dct_top dct_chk #(.W(W)) u_chk (
  .clk_i    (clk_i),
  .rst_n    (rst_n_s),
  .reg_wr   (reg_wr_i),
  .reg_addr (reg_addr_i),
  .irq      (irq_o),
  .tc       (tc_o),
  .cnt      (cnt),
  .sel      (sel),
  .run      (run),
  .alt      (ctrl_q.alt)
);

// File: tb/dct_top_tb_top.sv
module dct_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_CNT  = 2'd1;
  localparam logic [1:0] A_LA   = 2'd2;
  localparam logic [1:0] A_LB   = 2'd3;

  localparam logic [15:0] RUN  = 16'h0001;
  localparam logic [15:0] REP  = 16'h0002;
  localparam logic [15:0] ALT  = 16'h0004;
  localparam logic [15:0] IEN  = 16'h0008;
  localparam logic [15:0] SEXT = 16'h0010;
  localparam logic [15:0] SCAS = 16'h0020;
  localparam logic [15:0] SOFF = 16'h0030;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic        ext_cnt = 1'b0;
  logic        casc = 1'b0;
  logic        irq, tc, tout;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dct_top dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .reg_wr_i    (reg_wr),
    .reg_addr_i  (reg_addr),
    .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata),
    .ext_cnt_i   (ext_cnt),
    .casc_tick_i (casc),
    .irq_o       (irq),
    .tc_o        (tc),
    .tmr_out_o   (tout)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic clean();
    casc = 1'b0;
    wr(A_CTRL, 16'h0);
    wr(A_CNT, 16'h0);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(A_CTRL, v); chk("R1 ctrl", v, 16'h0);
    rd(A_CNT, v);  chk("R1 count", v, 16'h0);
    rd(A_LA, v);   chk("R1 limit A", v, 16'h0);
    chk("R1 irq", {15'h0, irq}, 16'h0);
    chk("R1 tc", {15'h0, tc}, 16'h0);
    chk("R1 out", {15'h0, tout}, 16'h1);
  endtask

  task automatic t_regs();
    logic [15:0] v;
    wr(A_LA, 16'h1234); rd(A_LA, v); chk("R12 limit A", v, 16'h1234);
    wr(A_LB, 16'hBEEF); rd(A_LB, v); chk("R12 limit B", v, 16'hBEEF);
    wr(A_CNT, 16'h0055); rd(A_CNT, v); chk("R12 count load", v, 16'h0055);
    clean();
  endtask

  task automatic t_internal();
    logic [15:0] v, keep;
    wr(A_LA, 16'd3);
    wr(A_CNT, 16'd0);
    wr(A_CTRL, RUN | REP | IEN);
    step(3); rd(A_CNT, v); chk("R2 before 4th clock", v, 16'd0);
    step(1); rd(A_CNT, v); chk("R2 first step", v, 16'd1);
    step(4); rd(A_CNT, v); chk("R2 second step", v, 16'd2);
    chk("R3 no early irq", {15'h0, irq}, 16'h0);
    step(4); rd(A_CNT, v); chk("R3 wrap to zero", v, 16'd0);
    chk("R3 irq pulse", {15'h0, irq}, 16'h1);
    chk("R11 tc pulse", {15'h0, tc}, 16'h1);
    chk("R8 out low at tc", {15'h0, tout}, 16'h0);
    step(1); chk("R3 irq one clock", {15'h0, irq}, 16'h0);
    step(2); chk("R8 out still low", {15'h0, tout}, 16'h0);
    step(1); chk("R8 out high after tick", {15'h0, tout}, 16'h1);
    step(8); chk("R5 second period irq", {15'h0, irq}, 16'h1);
    wr(A_CTRL, 16'h0);
    rd(A_CNT, keep);
    step(12); rd(A_CNT, v); chk("R2 hold while stopped", v, keep);
    clean();
  endtask

  task automatic t_single_casc();
    logic [15:0] v;
    casc = 1'b1;
    wr(A_LA, 16'd2);
    wr(A_CTRL, RUN | SCAS);
    step(1); rd(A_CNT, v); chk("R10 cascade step", v, 16'd1);
    step(1); rd(A_CNT, v); chk("R3 cascade wrap", v, 16'd0);
    chk("R11 tc without irq enable", {15'h0, tc}, 16'h1);
    chk("R3 irq masked", {15'h0, irq}, 16'h0);
    chk("R8 out low single run", {15'h0, tout}, 16'h0);
    rd(A_CTRL, v); chk("R6 run cleared", v & RUN, 16'h0);
    step(1); rd(A_CNT, v); chk("R6 stopped count", v, 16'd0);
    chk("R8 out restored after stop", {15'h0, tout}, 16'h1);
    wr(A_CTRL, RUN | REP | SOFF);
    step(8); rd(A_CNT, v); chk("R10 source 11 idle", v, 16'd0);
    clean();
  endtask

  task automatic t_full();
    logic [15:0] v;
    wr(A_LA, 16'h0000);
    wr(A_CNT, 16'hFFFE);
    casc = 1'b1;
    wr(A_CTRL, RUN | REP | SCAS | IEN);
    step(1); rd(A_CNT, v); chk("R4 reaches FFFF", v, 16'hFFFF);
    chk("R4 no tc at FFFF", {15'h0, tc}, 16'h0);
    step(1); rd(A_CNT, v); chk("R4 wraps", v, 16'h0000);
    chk("R4 irq at wrap", {15'h0, irq}, 16'h1);
    step(1); rd(A_CNT, v); chk("R4 zero not terminal", v, 16'h0001);
    chk("R4 no tc at 1", {15'h0, tc}, 16'h0);
    clean();
  endtask

  task automatic t_alt();
    logic [15:0] v;
    wr(A_LA, 16'd2);
    wr(A_LB, 16'd3);
    casc = 1'b1;
    wr(A_CTRL, RUN | REP | ALT | SCAS);
    step(1); chk("R7 out high toward A", {15'h0, tout}, 16'h1);
    step(1); chk("R7 out low toward B", {15'h0, tout}, 16'h0);
    rd(A_CTRL, v); chk("R7 select B", (v >> 6) & 16'h1, 16'h1);
    step(2); rd(A_CNT, v); chk("R7 count toward B", v, 16'd2);
    chk("R7 still B", {15'h0, tout}, 16'h0);
    step(1); chk("R7 back to A", {15'h0, tout}, 16'h1);
    rd(A_CTRL, v); chk("R7 select A", (v >> 6) & 16'h1, 16'h0);
    clean();
    wr(A_LA, 16'd1);
    wr(A_LB, 16'd1);
    casc = 1'b1;
    wr(A_CTRL, RUN | ALT | SCAS);
    step(1); rd(A_CTRL, v); chk("R6 alt keeps run after A", v & RUN, RUN);
    step(1); rd(A_CTRL, v); chk("R6 alt stops after B", v & RUN, 16'h0);
    chk("R7 out high at end", {15'h0, tout}, 16'h1);
    clean();
  endtask

  task automatic t_ext();
    logic [15:0] v;
    wr(A_LA, 16'd100);
    wr(A_CTRL, RUN | REP | SEXT);
    ext_cnt = 1'b1;
    step(2); rd(A_CNT, v); chk("R9 sync latency", v, 16'd0);
    step(1); rd(A_CNT, v); chk("R9 first edge", v, 16'd1);
    step(5); rd(A_CNT, v); chk("R9 held level once", v, 16'd1);
    ext_cnt = 1'b0;
    step(4);
    ext_cnt = 1'b1;
    step(3); rd(A_CNT, v); chk("R9 second edge", v, 16'd2);
    ext_cnt = 1'b0;
    clean();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(4);
    t_reset();
    t_regs();
    t_internal();
    t_single_casc();
    t_full();
    t_alt();
    t_ext();
    step(2);
    finish_run();
  end
endmodule